// File: doc/BRIEF.md
# Multi-Bank SDRAM Timing Tracker

This block keeps track of the open or closed state, the open row and the timing eligibility of four SDRAM banks. It sits between a command scheduler and the memory pins. Each cycle the scheduler presents one proposed command: activate, read, write, precharge, refresh, mode-set, or no-op. The command comes with its bank number, the A10 flag and a row address. The tracker answers combinationally whether that command is legal in this cycle. A legal command is taken as issued at the next rising edge, and the tracker updates its own state from it. An illegal command changes nothing.

Every spacing rule is held in small per-bank down-counters that stop at zero, plus two global counters. One global counter spaces activates across banks and the other guards the cycles after a mode-set. Each nanosecond minimum is turned into clocks by dividing by the clock period and rounding up. At the defaults (10 ns clock, burst of 4) this gives tRCD = 2, tRP = 2, tRRD = 2, tRC = 7, tRAS = 5 and tDAL = 2 + 2 = 4 clocks, and a write-recovery time (tRDL) of 2 clocks. A read or write with A10 high is an auto-precharge burst. It blocks every column command until the burst ends, and then closes its bank by itself.

Top module: `sdram_bank_timing_tracker`

## Requirements
- R1: A legal activate (op code 1) to bank b sets bank_open[b] and stores the row in open_row slice b, starting the next cycle. Slice and bit index b equal the cmd_bank value, and bit 0 of cmd_bank is the lower bank-select bit.
- R2: Op codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-set. A no-op is always legal and code 7 is never legal. An activate to an open bank is illegal, and a read or write to a closed bank is illegal.
- R3: A read or write is legal no sooner than tRCD clocks after the activate of its bank. An activate is legal no sooner than tRP clocks after a precharge of its bank.
- R4: Two activates to different banks are at least tRRD clocks apart. Two activates to the same bank are at least tRC clocks apart.
- R5: A precharge of an open bank is legal no sooner than tRAS clocks after that bank's activate. A precharge of a closed bank is legal and has no effect.
- R6: After a write, a precharge of that bank is legal no sooner than BURST_LEN-1+tRDL clocks after the write command.
- R7: A precharge with A10 high ignores cmd_bank. It is legal only when every open bank meets its precharge spacing, and it closes all banks.
- R8: A read or write with A10 high makes all column commands illegal for BURST_LEN clocks and clears its bank's open flag BURST_LEN clocks after the command. After such a read, an activate of that bank is legal from BURST_LEN+tRP clocks. After such a write, it is legal from BURST_LEN-1+tDAL clocks.
- R9: Column commands to an open bank may be issued on consecutive clocks.
- R10: Refresh and mode-set are legal only when all banks are closed and past their activate spacing. After a refresh, no activate for tRC clocks. After a mode-set, only a no-op for MRD_CLK clocks.
- R11: After reset all banks are closed, every open_row slice is zero, and an activate is legal.
- R12: An illegal command changes no state. For example, an activate to an open bank leaves its stored row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Proposed command code |
| cmd_bank | input | 2 | Bank number |
| cmd_a10 | input | 1 | All-bank flag on precharge, auto-precharge on read or write |
| cmd_row | input | 12 | Row address for an activate |
| cmd_ok | output | 1 | The proposed command is legal this cycle |
| bank_open | output | 4 | Per-bank open flag |
| open_row | output | 48 | Open row per bank, 12 bits per slice |

## Verification
Assertions in the RTL check the following on every cycle: every issued read or write follows its bank's activate by at least tRCD, every precharge of an open bank respects tRAS, and activates keep tRC, tRP and tRRD spacing. They also check that no command but a no-op issues inside the mode-set window, and that activates and column commands only reach closed and open banks respectively. The bench scenarios are what show behaviour that spans several rules together: write recovery, the A10 all-bank override, the self-closing of an auto-precharge burst, and refresh gating. They also show that a rejected command leaves the stored row untouched. A timing model in the bench covers these under long random command mixes.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_MRS = 3'd6
    } op_e;

    // One issued command as seen by one bank
    typedef struct packed {
        logic act;
        logic col;
        logic wr;
        logic ap;
        logic pre;
        logic rfsh;
    } bank_ev_t;

    // Minimum time in ps to whole clocks, rounded up
    function automatic int ps_to_clk(input int t_ps, input int period_ps);
        return (t_ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter load so that the guarded command becomes legal n clocks later
    function automatic int load_of(input int n);
        return (n > 0) ? n - 1 : 0;
    endfunction

endpackage

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int CW    = 3,
    parameter int L_RCD = 1,
    parameter int L_RAS = 4,
    parameter int L_RC  = 6,
    parameter int L_RP  = 1,
    parameter int L_WR  = 4,
    parameter int L_RAP = 5,
    parameter int L_WAP = 6,
    parameter int L_AP  = 3,
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RC  = 7,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_ev_t         ev,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             act_ok,
    output logic             col_ok,
    output logic             pre_ok,
    output logic             ap_busy
);

    typedef logic [CW-1:0] cnt_t;

    function automatic cnt_t dec(input cnt_t c);
        return (c == '0) ? '0 : c - cnt_t'(1);
    endfunction

    function automatic cnt_t hi(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

    logic open_q;
    logic ap_pend;
    cnt_t rcd_c;
    cnt_t pre_c;
    cnt_t act_c;
    cnt_t ap_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            ap_pend <= 1'b0;
            row_q   <= '0;
            rcd_c   <= '0;
            pre_c   <= '0;
            act_c   <= '0;
            ap_c    <= '0;
        end else begin
            rcd_c <= dec(rcd_c);
            pre_c <= dec(pre_c);
            act_c <= dec(act_c);
            ap_c  <= dec(ap_c);
            // auto-precharge burst reaches its end
            if (ap_pend && ap_c == cnt_t'(1)) begin
                open_q  <= 1'b0;
                ap_pend <= 1'b0;
            end
            if (ev.act) begin
                open_q <= 1'b1;
                row_q  <= row_in;
                rcd_c  <= cnt_t'(L_RCD);
                pre_c  <= hi(dec(pre_c), cnt_t'(L_RAS));
                act_c  <= hi(dec(act_c), cnt_t'(L_RC));
            end
            if (ev.col) begin
                if (ev.wr)
                    pre_c <= hi(dec(pre_c), cnt_t'(L_WR));
                if (ev.ap) begin
                    ap_c    <= cnt_t'(L_AP);
                    ap_pend <= 1'(L_AP != 0);
                    if (L_AP == 0)
                        open_q <= 1'b0;
                    act_c <= hi(dec(act_c), ev.wr ? cnt_t'(L_WAP) : cnt_t'(L_RAP));
                end
            end
            if (ev.pre && open_q) begin
                open_q <= 1'b0;
                act_c  <= hi(dec(act_c), cnt_t'(L_RP));
            end
            if (ev.rfsh)
                act_c <= hi(dec(act_c), cnt_t'(L_RC));
        end
    end

    assign is_open = open_q;
    assign act_ok  = !open_q && (act_c == '0);
    assign col_ok  = open_q && (rcd_c == '0) && !ap_pend;
    assign pre_ok  = !open_q || ((pre_c == '0) && !ap_pend);
    assign ap_busy = ap_pend;

    // Checker: cycles since the last activate and since the bank closed
    logic [15:0] age_act;
    logic [15:0] age_closed;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_act    <= 16'hFFFF;
            age_closed <= 16'hFFFF;
        end else begin
            age_act    <= ev.act ? 16'd1 : ((age_act == 16'hFFFF) ? age_act : age_act + 16'd1);
            age_closed <= open_q ? 16'd0 : ((age_closed == 16'hFFFF) ? age_closed : age_closed + 16'd1);
        end
    end

    p_rcd_r3: assert property (@(posedge clk) disable iff (rst)
        ev.col |-> age_act >= 16'(T_RCD));
    p_rp_r3: assert property (@(posedge clk) disable iff (rst)
        ev.act |-> age_closed >= 16'(T_RP - 1));
    p_rc_r4: assert property (@(posedge clk) disable iff (rst)
        ev.act |-> age_act >= 16'(T_RC));
    p_ras_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.pre && open_q) |-> age_act >= 16'(T_RAS));
    p_act_closed_r2: assert property (@(posedge clk) disable iff (rst)
        ev.act |-> !open_q);
    p_col_open_r2: assert property (@(posedge clk) disable iff (rst)
        ev.col |-> open_q);
    p_open_after_act_r1: assert property (@(posedge clk) disable iff (rst)
        ev.act |=> open_q);

endmodule

// File: rtl/sdram_trk_global.sv
module sdram_trk_global #(
    parameter int CW    = 3,
    parameter int L_RRD = 1,
    parameter int L_MRD = 1,
    parameter int T_RRD = 2,
    parameter int T_MRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_fire,
    input  logic any_fire,
    input  logic mrs_fire,
    output logic rrd_ok,
    output logic mrd_ok
);

    logic [CW-1:0] rrd_c;
    logic [CW-1:0] mrd_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_c <= '0;
            mrd_c <= '0;
        end else begin
            if (act_fire)
                rrd_c <= CW'(L_RRD);
            else if (rrd_c != '0)
                rrd_c <= rrd_c - CW'(1);
            if (mrs_fire)
                mrd_c <= CW'(L_MRD);
            else if (mrd_c != '0)
                mrd_c <= mrd_c - CW'(1);
        end
    end

    assign rrd_ok = (rrd_c == '0);
    assign mrd_ok = (mrd_c == '0);

    logic [15:0] age_act;
    logic [15:0] age_mrs;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_act <= 16'hFFFF;
            age_mrs <= 16'hFFFF;
        end else begin
            age_act <= act_fire ? 16'd1 : ((age_act == 16'hFFFF) ? age_act : age_act + 16'd1);
            age_mrs <= mrs_fire ? 16'd1 : ((age_mrs == 16'hFFFF) ? age_mrs : age_mrs + 16'd1);
        end
    end

    p_rrd_r4: assert property (@(posedge clk) disable iff (rst)
        act_fire |-> age_act >= 16'(T_RRD));
    p_mrd_r10: assert property (@(posedge clk) disable iff (rst)
        any_fire |-> age_mrs >= 16'(T_MRD));

endmodule

// File: rtl/sdram_trk_rules.sv
module sdram_trk_rules
    import sdram_trk_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  op_e                   op,
    input  logic [BW-1:0]         bank,
    input  logic                  a10,
    input  logic [NB-1:0]         act_ok,
    input  logic [NB-1:0]         col_ok,
    input  logic [NB-1:0]         pre_ok,
    input  logic [NB-1:0]         ap_busy,
    input  logic                  rrd_ok,
    input  logic                  mrd_ok,
    output logic                  ok,
    output bank_ev_t [NB-1:0]     ev,
    output logic                  act_fire,
    output logic                  any_fire,
    output logic                  mrs_fire
);

    logic all_idle;
    logic any_ap;
    logic all_pre;

    assign all_idle = &act_ok;
    assign any_ap   = |ap_busy;
    assign all_pre  = &pre_ok;

    always_comb begin
        case (op)
            OP_NOP:         ok = 1'b1;
            OP_ACT:         ok = mrd_ok && rrd_ok && act_ok[bank];
            OP_RD, OP_WR:   ok = mrd_ok && col_ok[bank] && !any_ap;
            OP_PRE:         ok = mrd_ok && (a10 ? all_pre : pre_ok[bank]);
            OP_REF, OP_MRS: ok = mrd_ok && all_idle;
            default:        ok = 1'b0;
        endcase
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            ev[b].act  = ok && (op == OP_ACT) && (bank == BW'(b));
            ev[b].col  = ok && ((op == OP_RD) || (op == OP_WR)) && (bank == BW'(b));
            ev[b].wr   = (op == OP_WR);
            ev[b].ap   = a10;
            ev[b].pre  = ok && (op == OP_PRE) && (a10 || (bank == BW'(b)));
            ev[b].rfsh = ok && (op == OP_REF);
        end
    end

    assign act_fire = ok && (op == OP_ACT);
    assign any_fire = ok && (op != OP_NOP);
    assign mrs_fire = ok && (op == OP_MRS);

endmodule

// File: rtl/sdram_bank_timing_tracker.sv
module sdram_bank_timing_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int ROW_W          = 12,
    parameter int CLK_PS         = 10000,
    parameter int T_RCD_PS       = 20000,
    parameter int T_RP_PS        = 20000,
    parameter int T_RRD_PS       = 15000,
    parameter int T_RC_PS        = 65000,
    parameter int T_RAS_PS       = 45000,
    parameter int T_DAL_EXTRA_PS = 20000,
    parameter int RDL_CLK        = 2,
    parameter int MRD_CLK        = 2,
    parameter int BURST_LEN      = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic                       cmd_a10,
    input  logic [ROW_W-1:0]           cmd_row,
    output logic                       cmd_ok,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);

    localparam int BW    = $clog2(NUM_BANKS);
    localparam int T_RCD = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int T_RP  = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int T_RRD = ps_to_clk(T_RRD_PS, CLK_PS);
    localparam int T_RC  = ps_to_clk(T_RC_PS, CLK_PS);
    localparam int T_RAS = ps_to_clk(T_RAS_PS, CLK_PS);
    localparam int T_DAL = RDL_CLK + ps_to_clk(T_DAL_EXTRA_PS, CLK_PS);

    localparam int L_RCD = load_of(T_RCD);
    localparam int L_RP  = load_of(T_RP);
    localparam int L_RRD = load_of(T_RRD);
    localparam int L_RC  = load_of(T_RC);
    localparam int L_RAS = load_of(T_RAS);
    localparam int L_WR  = load_of(BURST_LEN - 1 + RDL_CLK);
    localparam int L_RAP = load_of(BURST_LEN + T_RP);
    localparam int L_WAP = load_of(BURST_LEN - 1 + T_DAL);
    localparam int L_AP  = load_of(BURST_LEN);
    localparam int L_MRD = load_of(MRD_CLK);

    localparam int MAXL = imax(imax(imax(L_RCD, L_RP), imax(L_RRD, L_RC)),
                               imax(imax(L_RAS, L_WR), imax(imax(L_RAP, L_WAP), imax(L_AP, L_MRD))));
    localparam int CW   = imax(1, $clog2(MAXL + 1));

    op_e                      op;
    bank_ev_t [NUM_BANKS-1:0] ev;
    logic [NUM_BANKS-1:0]     act_ok;
    logic [NUM_BANKS-1:0]     col_ok;
    logic [NUM_BANKS-1:0]     pre_ok;
    logic [NUM_BANKS-1:0]     ap_busy;
    logic                     rrd_ok;
    logic                     mrd_ok;
    logic                     act_fire;
    logic                     any_fire;
    logic                     mrs_fire;

    assign op = op_e'(cmd_op);

    sdram_trk_rules #(
        .NB (NUM_BANKS),
        .BW (BW)
    ) u_rules (
        .op       (op),
        .bank     (cmd_bank),
        .a10      (cmd_a10),
        .act_ok   (act_ok),
        .col_ok   (col_ok),
        .pre_ok   (pre_ok),
        .ap_busy  (ap_busy),
        .rrd_ok   (rrd_ok),
        .mrd_ok   (mrd_ok),
        .ok       (cmd_ok),
        .ev       (ev),
        .act_fire (act_fire),
        .any_fire (any_fire),
        .mrs_fire (mrs_fire)
    );

    sdram_trk_global #(
        .CW    (CW),
        .L_RRD (L_RRD),
        .L_MRD (L_MRD),
        .T_RRD (T_RRD),
        .T_MRD (MRD_CLK)
    ) u_global (
        .clk      (clk),
        .rst      (rst),
        .act_fire (act_fire),
        .any_fire (any_fire),
        .mrs_fire (mrs_fire),
        .rrd_ok   (rrd_ok),
        .mrd_ok   (mrd_ok)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_trk_bank #(
            .ROW_W (ROW_W),
            .CW    (CW),
            .L_RCD (L_RCD),
            .L_RAS (L_RAS),
            .L_RC  (L_RC),
            .L_RP  (L_RP),
            .L_WR  (L_WR),
            .L_RAP (L_RAP),
            .L_WAP (L_WAP),
            .L_AP  (L_AP),
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RC  (T_RC),
            .T_RP  (T_RP)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ev      (ev[b]),
            .row_in  (cmd_row),
            .is_open (bank_open[b]),
            .row_q   (open_row[b*ROW_W +: ROW_W]),
            .act_ok  (act_ok[b]),
            .col_ok  (col_ok[b]),
            .pre_ok  (pre_ok[b]),
            .ap_busy (ap_busy[b])
        );
    end

    p_one_act_r1: assert property (@(posedge clk) disable iff (rst)
        $countones({ev[3].act, ev[2].act, ev[1].act, ev[0].act}) <= 1);
    p_illegal_still_r12: assert property (@(posedge clk) disable iff (rst)
        !cmd_ok |=> $stable(open_row));

endmodule

// File: tb/sdram_bank_timing_tracker_bench.sv
module sdram_bank_timing_tracker_bench;

    localparam int PER    = 10;
    localparam int BL     = 4;
    localparam int T_RCD  = (20 + PER - 1) / PER;
    localparam int T_RP   = (20 + PER - 1) / PER;
    localparam int T_RRD  = (15 + PER - 1) / PER;
    localparam int T_RC   = (65 + PER - 1) / PER;
    localparam int T_RAS  = (45 + PER - 1) / PER;
    localparam int T_RDL  = 2;
    localparam int T_DAL  = 2 + (20 + PER - 1) / PER;
    localparam int T_MRD  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic        cmd_a10 = 1'b0;
    logic [11:0] cmd_row = 12'd0;
    logic        cmd_ok;
    logic [3:0]  bank_open;
    logic [47:0] open_row;

    always #5 clk = ~clk;

    sdram_bank_timing_tracker u_sdram_bank_timing_tracker (
        .clk       (clk),
        .rst       (rst),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_a10   (cmd_a10),
        .cmd_row   (cmd_row),
        .cmd_ok    (cmd_ok),
        .bank_open (bank_open),
        .open_row  (open_row)
    );

    int total = 0;
    int bad   = 0;

    // timing model, all times in command-cycle numbers
    int          now;
    int          act_rdy[4];
    int          col_rdy[4];
    int          pre_rdy[4];
    int          close_at[4];
    bit          opn[4];
    logic [11:0] rw[4];
    int          rrd_rdy;
    int          mrd_rdy;
    int          colblk;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit good, input string tag, input string what, input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        now = 0; rrd_rdy = 0; mrd_rdy = 0; colblk = 0;
        for (int b = 0; b < 4; b++) begin
            act_rdy[b] = 0; col_rdy[b] = 0; pre_rdy[b] = 0;
            close_at[b] = -1; opn[b] = 1'b0; rw[b] = 12'd0;
        end
    endtask

    task automatic mdl_tick();
        for (int b = 0; b < 4; b++)
            if (close_at[b] >= 0 && now >= close_at[b]) begin
                opn[b] = 1'b0;
                close_at[b] = -1;
            end
    endtask

    function automatic bit mdl_ok(input int op, input int b, input bit a10);
        bit r;
        r = 1'b0;
        if (op != 0 && now < mrd_rdy) return 1'b0;
        case (op)
            0: r = 1'b1;
            1: r = !opn[b] && now >= act_rdy[b] && now >= rrd_rdy;
            2, 3: r = opn[b] && now >= col_rdy[b] && now >= colblk && close_at[b] < 0;
            4: begin
                r = 1'b1;
                for (int k = 0; k < 4; k++)
                    if ((a10 || k == b) && opn[k] && !(now >= pre_rdy[k] && close_at[k] < 0))
                        r = 1'b0;
            end
            5, 6: begin
                r = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (opn[k] || now < act_rdy[k]) r = 1'b0;
            end
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    task automatic mdl_upd(input int op, input int b, input bit a10, input logic [11:0] row);
        case (op)
            1: begin
                opn[b] = 1'b1; rw[b] = row;
                col_rdy[b] = now + T_RCD;
                pre_rdy[b] = mx(pre_rdy[b], now + T_RAS);
                act_rdy[b] = mx(act_rdy[b], now + T_RC);
                rrd_rdy = now + T_RRD;
            end
            2, 3: begin
                if (op == 3) pre_rdy[b] = mx(pre_rdy[b], now + BL - 1 + T_RDL);
                if (a10) begin
                    colblk = now + BL;
                    close_at[b] = now + BL;
                    act_rdy[b] = mx(act_rdy[b], (op == 2) ? now + BL + T_RP : now + BL - 1 + T_DAL);
                end
            end
            4: for (int k = 0; k < 4; k++)
                   if ((a10 || k == b) && opn[k]) begin
                       opn[k] = 1'b0;
                       act_rdy[k] = mx(act_rdy[k], now + T_RP);
                   end
            5: for (int k = 0; k < 4; k++) act_rdy[k] = mx(act_rdy[k], now + T_RC);
            6: mrd_rdy = now + T_MRD;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int op, input bit a10);
        case (op)
            1: return "R4";
            2, 3: return a10 ? "R8" : "R3";
            4: return a10 ? "R7" : "R5";
            5, 6: return "R10";
            default: return "R2";
        endcase
    endfunction

    // one command cycle; want < 0 means model only
    task automatic step(input int op, input int b, input bit a10, input logic [11:0] row,
                        input int want, input string tag);
        bit exp;
        @(negedge clk);
        mdl_tick();
        cmd_op = 3'(op); cmd_bank = 2'(b); cmd_a10 = a10; cmd_row = row;
        #1;
        exp = mdl_ok(op, b, a10);
        chk(cmd_ok == exp, tag, "legal vs model", int'(cmd_ok), int'(exp));
        if (want >= 0)
            chk(cmd_ok == 1'(want), tag, "legal directed", int'(cmd_ok), want);
        for (int k = 0; k < 4; k++) begin
            chk(bank_open[k] == opn[k], "R1", "bank_open", int'(bank_open[k]), int'(opn[k]));
            if (opn[k])
                chk(open_row[k*12 +: 12] == rw[k], "R1", "open_row", int'(open_row[k*12 +: 12]), int'(rw[k]));
        end
        if (exp) mdl_upd(op, b, a10, row);
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1'b0, 12'd0, 1, "R2");
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int op;
        mdl_reset();
        void'($urandom(32'd4321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk(bank_open == 4'd0, "R11", "bank_open after reset", int'(bank_open), 0);
        chk(open_row == 48'd0, "R11", "open_row after reset", int'(open_row[31:0]), 0);

        // directed corner cases, one step per cycle
        step(1, 0, 1'b0, 12'h123, 1, "R1");   // t0 ACT bank0
        step(2, 0, 1'b0, 12'h0,   0, "R3");   // t1 read before tRCD
        step(1, 1, 1'b0, 12'h0AB, 1, "R4");   // t2 ACT bank1 after tRRD
        step(2, 0, 1'b0, 12'h0,   1, "R3");   // t3 read at tRCD
        step(4, 0, 1'b0, 12'h0,   0, "R5");   // t4 precharge before tRAS
        step(3, 0, 1'b0, 12'h0,   1, "R9");   // t5 write
        step(3, 0, 1'b0, 12'h0,   1, "R9");   // t6 back-to-back write
        step(1, 0, 1'b0, 12'h555, 0, "R2");   // t7 ACT to open bank
        step(4, 0, 1'b0, 12'h0,   0, "R6");   // t8 inside write recovery
        chk(open_row[11:0] == 12'h123, "R12", "row kept after illegal ACT", int'(open_row[11:0]), 'h123);
        idle(2);                              // t9..t10
        step(4, 0, 1'b0, 12'h0,   1, "R6");   // t11 recovery done
        step(1, 0, 1'b0, 12'h0,   0, "R3");   // t12 ACT inside tRP
        step(1, 0, 1'b0, 12'h321, 1, "R3");   // t13 ACT after tRP
        step(4, 2, 1'b1, 12'h0,   0, "R7");   // t14 all-bank, bank0 tRAS pending
        idle(3);                              // t15..t17
        step(4, 2, 1'b1, 12'h0,   1, "R7");   // t18 all-bank precharge
        step(5, 0, 1'b0, 12'h0,   0, "R10");  // t19 refresh inside tRP
        chk(bank_open == 4'd0, "R7", "all banks closed", int'(bank_open), 0);
        step(5, 0, 1'b0, 12'h0,   1, "R10");  // t20 refresh
        step(1, 2, 1'b0, 12'h0,   0, "R10");  // t21 ACT inside refresh window
        idle(5);                              // t22..t26
        step(1, 2, 1'b0, 12'h777, 1, "R10");  // t27 ACT bank2
        idle(1);                              // t28
        step(2, 2, 1'b1, 12'h0,   1, "R8");   // t29 read with auto-precharge
        step(2, 2, 1'b0, 12'h0,   0, "R8");   // t30 column blocked
        idle(2);                              // t31..t32
        chk(bank_open[2] == 1'b1, "R8", "open during burst", int'(bank_open[2]), 1);
        step(0, 0, 1'b0, 12'h0,   1, "R8");   // t33 burst ended
        chk(bank_open[2] == 1'b0, "R8", "closed after burst", int'(bank_open[2]), 0);
        step(1, 2, 1'b0, 12'h0,   0, "R8");   // t34 ACT before BL+tRP
        step(1, 2, 1'b0, 12'h010, 1, "R8");   // t35 ACT allowed
        idle(1);                              // t36
        step(3, 2, 1'b1, 12'h0,   1, "R8");   // t37 write with auto-precharge
        idle(5);                              // t38..t42
        step(1, 2, 1'b0, 12'h0,   0, "R8");   // t43 inside tDAL
        step(1, 2, 1'b0, 12'h020, 1, "R8");   // t44 ACT allowed
        idle(4);                              // t45..t48
        step(4, 0, 1'b1, 12'h0,   1, "R7");   // t49 close all
        step(6, 0, 1'b0, 12'h0,   0, "R10");  // t50 mode-set inside tRP
        step(6, 0, 1'b0, 12'h0,   1, "R10");  // t51 mode-set
        step(1, 0, 1'b0, 12'h0,   0, "R10");  // t52 ACT inside mode-set window
        step(1, 0, 1'b0, 12'h444, 1, "R10");  // t53 ACT allowed
        step(7, 0, 1'b0, 12'h0,   0, "R2");   // undefined code
        step(0, 0, 1'b0, 12'h0,   1, "R2");

        // constrained random mix against the model
        for (int i = 0; i < 2500; i++) begin
            int r;
            bit a;
            r = int'($urandom % 16);
            if (r < 5)       op = 1;
            else if (r < 8)  op = 2;
            else if (r < 10) op = 3;
            else if (r < 13) op = 4;
            else if (r < 14) op = 5;
            else if (r < 15) op = 6;
            else             op = 0;
            a = ($urandom % 4) == 0;
            step(op, int'($urandom % 4), a, 12'($urandom), -1, tag_of(op, a));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule